// File: doc/BRIEF.md
# Fractional Per-Cycle Event Scheduler

This block decides, once per isochronous cycle, how many audio events (one sample per channel) go into the packet for that cycle. The selected sample rate divided by the fixed cycle rate of 8000 per second is held exactly, as a whole part plus a remainder over 8000. Each cycle tick adds that step to a carried leftover, picks a count from the sum and, when the packet can really go out, keeps what was not sent for the next cycle. A 44.1 kHz stream therefore averages 5 41/80 events and alternates between packets of 5 and 6.

Two modes are offered. In the streaming mode every whole event that is ready is sent. In the burst mode a packet carries either exactly one timestamp interval of events or none. A packet is held back when the sample store reports fewer bytes than the count needs, or when the downstream side has no packet slot free; the leftover is then left alone, so no fraction is lost. The block also reports the largest count its current setting can produce and the payload size that implies, for sizing packet buffers.

Top module: `cycle_event_sched`

## Requirements
- R1: Rate codes on `cfg_rate_sel` are 0=32000, 1=44100, 2=48000, 3=88200, 4=96000, 5=176400, 6=192000 Hz, with timestamp interval 8 for codes 0-2, 16 for codes 3-4 and 32 for codes 5-6; a load with code 7 is ignored and leaves the whole setting and the leftover unchanged.
- R2: On each tick the candidate sum is leftover plus step (rate/8000 as quotient and remainder), the remainders added with carry into the whole part; the stored remainder is always below 8000.
- R3: With `cfg_blocking`=0 the count is the whole part of the candidate sum (44.1 kHz from a cleared leftover gives 5, 6, 5, 6 ...).
- R4: With `cfg_blocking`=1 the count is the interval when the whole part of the sum reaches it, and 0 otherwise; a count of 0 still goes out as a packet.
- R5: After a packet goes out, the leftover whole part becomes the sum's whole part minus the count and the remainder of the sum is kept.
- R6: A tick is stalled when `avail_bytes` < count x channels x 2 or `slot_free`=0; a stalled tick pulses `stall`, gives no `emit_valid`, and leaves the leftover unchanged.
- R7: `emit_valid`, `emit_count` and `stall` are registered one-cycle pulses following the clock edge that samples the tick; `emit_count` is 0 whenever `emit_valid` is 0.
- R8: A valid load clears the leftover to zero; a tick in the same cycle as a valid load is dropped, giving neither `emit_valid` nor `stall`.
- R9: `max_count` is the interval in burst mode, else the step's quotient rounded up; `max_payload` = `max_count` x channels x 4 + 8.
- R10: After reset the setting is 32000 Hz, streaming mode, 2 channels, with a cleared leftover and all pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Apply rate, mode and channel setting |
| cfg_rate_sel | input | 3 | Rate code, see R1 |
| cfg_blocking | input | 1 | 1 = burst mode, 0 = streaming mode |
| cfg_chans | input | CHAN_W (6) | Channels per event |
| cycle_tick | input | 1 | One pulse per isochronous cycle |
| avail_bytes | input | BYTES_W (16) | Bytes held in the sample store |
| slot_free | input | 1 | A packet slot is free downstream |
| emit_valid | output | 1 | Packet sent for the last tick |
| emit_count | output | CNT_W (8) | Events in that packet |
| stall | output | 1 | Last tick was held back |
| max_count | output | CNT_W (8) | Largest count for the current setting |
| max_payload | output | PAY_W (16) | Largest payload in bytes |

## Verification
The clash that matters is a reconfiguration landing in the same cycle as a cycle tick: the clear of the leftover and the commit of a packet both want to write it. The bench first builds up a non-zero leftover at 192 kHz in burst mode, then raises load and tick together and checks that no pulse appears; the next lone tick must give 0 events, which is only true if the leftover was cleared instead of advanced (a committed or uncleared leftover would give 32). The stall path is crossed with carry cycles by starving the store exactly one byte short on a tick that would carry a remainder.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int unsigned RATE_SEL_W = 3;
  localparam int unsigned NUM_RATES  = 7;
  localparam int unsigned TBL_DEPTH  = 1 << RATE_SEL_W;

  // Sample rate in Hz for each code.
  function automatic int unsigned rate_of(input int unsigned idx);
    case (idx)
      0:       return 32000;
      1:       return 44100;
      2:       return 48000;
      3:       return 88200;
      4:       return 96000;
      5:       return 176400;
      6:       return 192000;
      default: return 0;
    endcase
  endfunction

  // Timestamp interval (events per burst) for each code.
  function automatic int unsigned burst_of(input int unsigned idx);
    if (idx < 3)      return 8;
    else if (idx < 5) return 16;
    else              return 32;
  endfunction

endpackage

// File: rtl/sched_cfg.sv
module sched_cfg
  import sched_pkg::*;
#(
  parameter int unsigned DENOM  = 8000,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CHAN_W = 6,
  parameter int unsigned REM_W  = $clog2(DENOM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_load,
  input  logic [RATE_SEL_W-1:0] cfg_rate_sel,
  input  logic                  cfg_blocking,
  input  logic [CHAN_W-1:0]     cfg_chans,
  output logic                  load_ok,
  output logic [CNT_W-1:0]      step_int,
  output logic [REM_W-1:0]      step_rem,
  output logic [CNT_W-1:0]      burst,
  output logic                  blocking,
  output logic [CHAN_W-1:0]     chans
);

  localparam logic [RATE_SEL_W-1:0] RATE_LIMIT = RATE_SEL_W'(NUM_RATES);
  localparam logic [CNT_W-1:0]  RST_INT   = CNT_W'(rate_of(0) / DENOM);
  localparam logic [REM_W-1:0]  RST_REM   = REM_W'(rate_of(0) % DENOM);
  localparam logic [CNT_W-1:0]  RST_BURST = CNT_W'(burst_of(0));
  localparam logic [CHAN_W-1:0] RST_CHANS = CHAN_W'(2);

  logic [CNT_W-1:0] tbl_int   [TBL_DEPTH];
  logic [REM_W-1:0] tbl_rem   [TBL_DEPTH];
  logic [CNT_W-1:0] tbl_burst [TBL_DEPTH];

  // Per-code quotient, remainder and interval, folded at elaboration.
  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_rate
    if (g < NUM_RATES) begin : g_valid
      localparam int unsigned HZ = rate_of(g);
      assign tbl_int[g]   = CNT_W'(HZ / DENOM);
      assign tbl_rem[g]   = REM_W'(HZ % DENOM);
      assign tbl_burst[g] = CNT_W'(burst_of(g));
    end else begin : g_unused
      assign tbl_int[g]   = '0;
      assign tbl_rem[g]   = '0;
      assign tbl_burst[g] = '0;
    end
  end

  assign load_ok = cfg_load && (cfg_rate_sel < RATE_LIMIT);

  logic [CNT_W-1:0]  step_int_d, burst_d;
  logic [REM_W-1:0]  step_rem_d;
  logic              blocking_d;
  logic [CHAN_W-1:0] chans_d;

  always_comb begin
    step_int_d = step_int;
    step_rem_d = step_rem;
    burst_d    = burst;
    blocking_d = blocking;
    chans_d    = chans;
    if (load_ok) begin
      step_int_d = tbl_int[cfg_rate_sel];
      step_rem_d = tbl_rem[cfg_rate_sel];
      burst_d    = tbl_burst[cfg_rate_sel];
      blocking_d = cfg_blocking;
      chans_d    = cfg_chans;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_int <= RST_INT;
      step_rem <= RST_REM;
      burst    <= RST_BURST;
      blocking <= 1'b0;
      chans    <= RST_CHANS;
    end else if (load_ok) begin
      step_int <= step_int_d;
      step_rem <= step_rem_d;
      burst    <= burst_d;
      blocking <= blocking_d;
      chans    <= chans_d;
    end
  end

  // R1: a load with an out-of-range code changes nothing
  p_bad_code_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !(cfg_rate_sel < RATE_LIMIT)) |=>
      ($stable(step_int) && $stable(step_rem) && $stable(burst) && $stable(chans)));

  // R1: the interval is always a single power of two
  p_burst_pow2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(burst) == 1);

  // R2: the stored step remainder stays below the denominator
  p_step_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_rem < REM_W'(DENOM));

endmodule

// File: rtl/sched_accum.sv
module sched_accum #(
  parameter int unsigned DENOM = 8000,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REM_W = $clog2(DENOM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             commit,
  input  logic [CNT_W-1:0] step_int,
  input  logic [REM_W-1:0] step_rem,
  input  logic [CNT_W-1:0] burst,
  input  logic             blocking,
  output logic [CNT_W-1:0] count
);

  localparam logic [REM_W:0] DENOM_X = (REM_W+1)'(DENOM);

  logic [CNT_W-1:0] lo_int, lo_int_d;
  logic [REM_W-1:0] lo_rem, lo_rem_d;
  logic [REM_W:0]   rem_sum;
  logic             carry;
  logic [CNT_W-1:0] sum_int;
  logic [REM_W-1:0] sum_rem;

  // Candidate sum: leftover plus step, remainder carried into the whole part.
  always_comb begin
    rem_sum = {1'b0, lo_rem} + {1'b0, step_rem};
    carry   = (rem_sum >= DENOM_X);
    sum_rem = carry ? REM_W'(rem_sum - DENOM_X) : REM_W'(rem_sum);
    sum_int = lo_int + step_int + CNT_W'(carry);
  end

  // Count selection by mode.
  always_comb begin
    if (blocking) begin
      count = (sum_int >= burst) ? burst : '0;
    end else begin
      count = sum_int;
    end
  end

  always_comb begin
    lo_int_d = lo_int;
    lo_rem_d = lo_rem;
    if (clear) begin
      lo_int_d = '0;
      lo_rem_d = '0;
    end else if (commit) begin
      lo_int_d = sum_int - count;
      lo_rem_d = sum_rem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_int <= '0;
      lo_rem <= '0;
    end else if (clear || commit) begin
      lo_int <= lo_int_d;
      lo_rem <= lo_rem_d;
    end
  end

  // R2: leftover remainder stays below the denominator
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rem < REM_W'(DENOM));

  // R6: a held-back tick leaves the leftover alone
  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !commit && !clear) |=> ($stable(lo_int) && $stable(lo_rem)));

  // R8: a valid load empties the leftover
  p_clear_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lo_int == '0 && lo_rem == '0));

  // R4: burst mode commits all or nothing
  p_burst_all_or_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blocking && commit) |-> (count == '0 || count == burst));

  // R3: streaming mode leaves no whole event behind after a commit
  p_stream_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!blocking && commit && !clear) |=> (lo_int == '0));

endmodule

// File: rtl/sched_gate.sv
module sched_gate #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CHAN_W  = 6,
  parameter int unsigned BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               clear,
  input  logic [CNT_W-1:0]   count,
  input  logic [CHAN_W-1:0]  chans,
  input  logic [BYTES_W-1:0] avail_bytes,
  input  logic               slot_free,
  output logic               commit,
  output logic               emit_valid,
  output logic [CNT_W-1:0]   emit_count,
  output logic               stall
);

  logic [BYTES_W-1:0] need_bytes;
  logic               have_data;
  logic               stall_d;
  logic [CNT_W-1:0]   emit_count_d;

  // Two bytes per sample per channel.
  always_comb begin
    need_bytes   = (BYTES_W'(count) * BYTES_W'(chans)) << 1;
    have_data    = (avail_bytes >= need_bytes);
    commit       = tick && !clear && slot_free && have_data;
    stall_d      = tick && !clear && !commit;
    emit_count_d = commit ? count : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_valid <= 1'b0;
      emit_count <= '0;
      stall      <= 1'b0;
    end else begin
      emit_valid <= commit;
      emit_count <= emit_count_d;
      stall      <= stall_d;
    end
  end

  // R6: a cycle never reports both a packet and a stall
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(emit_valid && stall));

  // R7: a committed tick shows one cycle later
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (emit_valid && emit_count == $past(count)));

  // R7: the count reads zero with no packet
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !emit_valid |-> (emit_count == '0));

  // R8: a tick alongside a load leaves no trace
  p_drop_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!emit_valid && !stall));

endmodule

// File: rtl/cycle_event_sched.sv
module cycle_event_sched
  import sched_pkg::*;
#(
  parameter int unsigned DENOM   = 8000,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CHAN_W  = 6,
  parameter int unsigned BYTES_W = 16,
  parameter int unsigned PAY_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_load,
  input  logic [RATE_SEL_W-1:0] cfg_rate_sel,
  input  logic                  cfg_blocking,
  input  logic [CHAN_W-1:0]     cfg_chans,
  input  logic                  cycle_tick,
  input  logic [BYTES_W-1:0]    avail_bytes,
  input  logic                  slot_free,
  output logic                  emit_valid,
  output logic [CNT_W-1:0]      emit_count,
  output logic                  stall,
  output logic [CNT_W-1:0]      max_count,
  output logic [PAY_W-1:0]      max_payload
);

  localparam int unsigned REM_W = $clog2(DENOM);

  logic              load_ok;
  logic [CNT_W-1:0]  step_int;
  logic [REM_W-1:0]  step_rem;
  logic [CNT_W-1:0]  burst;
  logic              blocking;
  logic [CHAN_W-1:0] chans;
  logic [CNT_W-1:0]  count;
  logic              commit;

  sched_cfg #(
    .DENOM (DENOM),
    .CNT_W (CNT_W),
    .CHAN_W(CHAN_W),
    .REM_W (REM_W)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_rate_sel(cfg_rate_sel),
    .cfg_blocking(cfg_blocking),
    .cfg_chans   (cfg_chans),
    .load_ok     (load_ok),
    .step_int    (step_int),
    .step_rem    (step_rem),
    .burst       (burst),
    .blocking    (blocking),
    .chans       (chans)
  );

  sched_accum #(
    .DENOM(DENOM),
    .CNT_W(CNT_W),
    .REM_W(REM_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cycle_tick),
    .clear   (load_ok),
    .commit  (commit),
    .step_int(step_int),
    .step_rem(step_rem),
    .burst   (burst),
    .blocking(blocking),
    .count   (count)
  );

  sched_gate #(
    .CNT_W  (CNT_W),
    .CHAN_W (CHAN_W),
    .BYTES_W(BYTES_W)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (cycle_tick),
    .clear      (load_ok),
    .count      (count),
    .chans      (chans),
    .avail_bytes(avail_bytes),
    .slot_free  (slot_free),
    .commit     (commit),
    .emit_valid (emit_valid),
    .emit_count (emit_count),
    .stall      (stall)
  );

  // Worst-case count and payload (two header quadlets, one quadlet per sample).
  always_comb begin
    max_count   = blocking ? burst : (step_int + CNT_W'(step_rem != '0));
    max_payload = ((PAY_W'(max_count) * PAY_W'(chans)) << 2) + PAY_W'(8);
  end

  // R9: no packet ever exceeds the reported worst case
  p_within_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !load_ok) |-> (count <= max_count));

endmodule

// File: tb/cycle_event_sched_tb.sv
module cycle_event_sched_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_load;
  logic [2:0]  cfg_rate_sel;
  logic        cfg_blocking;
  logic [5:0]  cfg_chans;
  logic        cycle_tick;
  logic [15:0] avail_bytes;
  logic        slot_free;
  logic        emit_valid;
  logic [7:0]  emit_count;
  logic        stall;
  logic [7:0]  max_count;
  logic [15:0] max_payload;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  cycle_event_sched u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_rate_sel(cfg_rate_sel),
    .cfg_blocking(cfg_blocking),
    .cfg_chans   (cfg_chans),
    .cycle_tick  (cycle_tick),
    .avail_bytes (avail_bytes),
    .slot_free   (slot_free),
    .emit_valid  (emit_valid),
    .emit_count  (emit_count),
    .stall       (stall),
    .max_count   (max_count),
    .max_payload (max_payload)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // 44.1 kHz streaming, 2 channels, from a cleared leftover:
  // {avail_bytes, slot_free, exp_valid, exp_stall, exp_count}
  localparam logic [26:0] VEC [8] = '{
    {16'd255, 1'b1, 1'b1, 1'b0, 8'd5},  // rem 4100
    {16'd255, 1'b1, 1'b1, 1'b0, 8'd6},  // carry, rem 200
    {16'd255, 1'b1, 1'b1, 1'b0, 8'd5},  // rem 4300
    {16'd23,  1'b1, 1'b0, 1'b1, 8'd0},  // needs 24 bytes: stall
    {16'd24,  1'b1, 1'b1, 1'b0, 8'd6},  // same carry now goes, rem 400
    {16'd255, 1'b0, 1'b0, 1'b1, 8'd0},  // no slot: stall
    {16'd255, 1'b1, 1'b1, 1'b0, 8'd5},  // rem 4500
    {16'd255, 1'b1, 1'b1, 1'b0, 8'd6}   // carry, rem 600
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input bit ev, input bit st, input int cnt);
    check(emit_valid == ev, req, "emit_valid", int'(emit_valid), int'(ev));
    check(stall == st, req, "stall", int'(stall), int'(st));
    check(int'(emit_count) == cnt, req, "emit_count", int'(emit_count), cnt);
  endtask

  task automatic chk_max(input string req, input int mc, input int mp);
    check(int'(max_count) == mc, req, "max_count", int'(max_count), mc);
    check(int'(max_payload) == mp, req, "max_payload", int'(max_payload), mp);
  endtask

  task automatic load(input logic [2:0] code, input bit blk, input logic [5:0] ch);
    @(negedge clk);
    cfg_load     = 1'b1;
    cfg_rate_sel = code;
    cfg_blocking = blk;
    cfg_chans    = ch;
    @(negedge clk);
    cfg_load     = 1'b0;
  endtask

  // Tick for one cycle; outputs are visible at the following negedge.
  task automatic tick(input logic [15:0] av, input bit sl);
    @(negedge clk);
    avail_bytes = av;
    slot_free   = sl;
    cycle_tick  = 1'b1;
    @(negedge clk);
    cycle_tick  = 1'b0;
  endtask

  initial begin
    rst_n        = 1'b0;
    cfg_load     = 1'b0;
    cfg_rate_sel = 3'd0;
    cfg_blocking = 1'b0;
    cfg_chans    = 6'd2;
    cycle_tick   = 1'b0;
    avail_bytes  = 16'd0;
    slot_free    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk_out("R10", 1'b0, 1'b0, 0);
    chk_max("R10", 4, 40);

    // R1 / R3: 32 kHz streaming gives 4 per cycle
    tick(16'd255, 1'b1);
    chk_out("R1", 1'b1, 1'b0, 4);

    // R9: 44.1 kHz streaming, 2 channels
    load(3'd1, 1'b0, 6'd2);
    chk_max("R9", 6, 56);

    // Table walk: R2, R3, R5, R6, R7
    for (int i = 0; i < 8; i++) begin
      tick(VEC[i][26:11], VEC[i][10]);
      chk_out(VEC[i][8] ? "R6" : "R3 R5", VEC[i][9], VEC[i][8], int'(VEC[i][7:0]));
    end
    // R7: pulses last one cycle
    @(negedge clk);
    chk_out("R7", 1'b0, 1'b0, 0);

    // R4: 48 kHz burst, interval 8, step 6
    load(3'd2, 1'b1, 6'd2);
    chk_max("R9", 8, 72);
    tick(16'd0, 1'b1);            // sum 6: zero-event packet needs no data
    chk_out("R4", 1'b1, 1'b0, 0);
    tick(16'd255, 1'b1);          // sum 12 -> 8, left 4
    chk_out("R4", 1'b1, 1'b0, 8);
    tick(16'd255, 1'b1);          // sum 10 -> 8, left 2
    chk_out("R4", 1'b1, 1'b0, 8);
    tick(16'd255, 1'b1);          // sum 8 -> 8, left 0
    chk_out("R5", 1'b1, 1'b0, 8);
    tick(16'd255, 1'b1);          // sum 6 -> 0
    chk_out("R5", 1'b1, 1'b0, 0);

    // R1: code 7 is ignored, setting stays 48 kHz burst
    load(3'd7, 1'b0, 6'd1);
    chk_max("R1", 8, 72);
    tick(16'd255, 1'b1);          // leftover 6 kept: sum 12 -> 8
    chk_out("R1", 1'b1, 1'b0, 8);

    // R1 / R9: 192 kHz burst, interval 32, step 24
    load(3'd6, 1'b1, 6'd2);
    chk_max("R9", 32, 264);
    tick(16'd255, 1'b1);          // sum 24 -> 0, left 24
    chk_out("R4", 1'b1, 1'b0, 0);

    // R8: load and tick together; tick dropped, leftover cleared
    @(negedge clk);
    cfg_load     = 1'b1;
    cfg_rate_sel = 3'd6;
    cfg_blocking = 1'b1;
    cfg_chans    = 6'd2;
    cycle_tick   = 1'b1;
    avail_bytes  = 16'd255;
    slot_free    = 1'b1;
    @(negedge clk);
    cfg_load     = 1'b0;
    cycle_tick   = 1'b0;
    chk_out("R8", 1'b0, 1'b0, 0);
    tick(16'd255, 1'b1);          // cleared: sum 24 -> 0 (not 32)
    chk_out("R8", 1'b1, 1'b0, 0);
    tick(16'd255, 1'b1);          // sum 48 -> 32
    chk_out("R4", 1'b1, 1'b0, 32);

    // R9 / R2: 88.2 kHz streaming, 1 channel, step 11 r200
    load(3'd3, 1'b0, 6'd1);
    chk_max("R9", 12, 56);
    tick(16'd255, 1'b1);
    chk_out("R2", 1'b1, 1'b0, 11);

    // R10: reset mid-stream restores the default setting
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_max("R10", 4, 40);
    chk_out("R10", 1'b0, 1'b0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule